// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block divides a fast clock taken from an oscillator under control by a programmable total ratio of P·N + A. It has three parts. The first is a dual-modulus prescaler, modelled as a digital counter that divides by either P or P+1. The second is a swallow counter that holds the prescaler at P+1 for the first A prescaler cycles of each frame. The third is a main counter that closes the frame after N prescaler cycles. Each frame ends with a one-cycle comparison pulse `fp`. A separate programmable divider on the reference oscillator clock gives one pulse `fr` every R reference cycles. A phase comparator downstream compares the two pulse trains, and the loop settles at f_out = (P·N + A)·f_ref / R.

The settings A, N, R and the prescaler select bit come from a register bank outside this block and may change at any time. The divider copies a new A, N or select value only when a frame wraps. It copies a new R value only when the reference divider wraps. As a result no frame and no reference period is ever cut short. The divide-by-(P+1) control is brought out on a port so that the modulus handshake can be observed.

Two finite-state machines control the block. The frame controller has three states. `FR_LOAD` is entered after reset and takes the first settings. `FR_SWALLOW` holds the prescaler at P+1. `FR_MAIN` holds it at P. Its transitions are:
- `T_START`: `FR_LOAD` to `FR_SWALLOW`, or to `FR_MAIN` when A = 0.
- `T_RELEASE`: `FR_SWALLOW` to `FR_MAIN` once A prescaler cycles have elapsed.
- `T_WRAP`: at the end of the last prescaler cycle, from either running state back to `FR_SWALLOW`, or to `FR_MAIN` when the new A = 0. New settings are copied on this transition.

The reference controller has two states, `RF_LOAD` and `RF_COUNT`. Its transitions are `T_RSTART` out of load and `T_RWRAP`, which emits `fr` and copies a new R.

Top module: `pswallow_synth_div`

## Requirements
- R1: The interval between successive `fp` pulses is exactly P·N + A cycles of `clk_vco`, for 3 ≤ N ≤ 2047 and 0 ≤ A ≤ 127 with A < N.
- R2: Within each frame, `mod_ctl` is high (prescaler divides by P+1) for exactly A·(P+1) `clk_vco` cycles at the start of the frame, then low until the frame ends; `mod_ctl` only changes at a prescaler cycle boundary.
- R3: When A = 0, `mod_ctl` stays low for the whole frame.
- R4: With `HIGH_BAND` = 0, `psel` = 1 selects P = 8 and `psel` = 0 selects P = 16; with `HIGH_BAND` = 1, `psel` = 1 selects P = 64 and `psel` = 0 selects P = 128.
- R5: A change of `swallow_a`, `main_n` or `psel` during a frame has no effect on that frame; the new values govern the following frame.
- R6: The interval between successive `fr` pulses is exactly R cycles of `clk_osc` for 3 ≤ R ≤ 16383, and a change of `ref_r` takes effect only after the next `fr` pulse.
- R7: `fp` and `fr` are each high for a single cycle of their clock.
- R8: While `rst_n` is low, `fp`, `fr` and `mod_ctl` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast input clock derived from the controlled oscillator |
| clk_osc | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| swallow_a | input | 7 | Swallow count A |
| main_n | input | 11 | Main counter ratio N |
| ref_r | input | 14 | Reference ratio R |
| psel | input | 1 | Prescaler pair select (1 = smaller modulus) |
| fp | output | 1 | One-cycle pulse per divided frame, `clk_vco` domain |
| fr | output | 1 | One-cycle pulse per reference period, `clk_osc` domain |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |

## Verification
The assertions assume that N and R are never below 3 and that A stays below N. Under those limits the frames and the reference periods are long enough that a pulse can never repeat on the next cycle, and the swallow phase always ends before the main count does. The stimulus only ever applies settings inside those limits. It sweeps every legal A for each N from 3 to 8 under both select values, and adds a few long ratios, one high-band instance and a sweep of R. Each new setting is driven two cycles after a pulse, so that the frame still running shows the old ratio and the one after it shows the new ratio.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    typedef enum logic [1:0] {
        FR_LOAD    = 2'd0,
        FR_SWALLOW = 2'd1,
        FR_MAIN    = 2'd2
    } frame_state_t;

    typedef enum logic {
        RF_LOAD  = 1'b0,
        RF_COUNT = 1'b1
    } ref_state_t;

endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            mc,
    input  logic [PC_W-1:0] p_base,
    output logic            tick
);
    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] term;

    always_comb begin
        term = p_base + PC_W'(mc) - PC_W'(1);
        tick = run && (pcnt == term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!run || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + PC_W'(1);
    end

    // The count never passes the larger modulus.
    assert_pcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= p_base);

    // The modulus select only moves at a prescaler cycle boundary.
    assert_mc_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$stable(mc)) |-> (pcnt == '0));

endmodule

// File: rtl/pswallow_frame_ctrl.sv
module pswallow_frame_ctrl
    import pswallow_pkg::*;
#(
    parameter int A_W   = 7,
    parameter int N_W   = 11,
    parameter int PC_W  = 8,
    parameter int P_SET = 8,
    parameter int P_CLR = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [A_W-1:0]  a_in,
    input  logic [N_W-1:0]  n_in,
    input  logic            psel_in,
    output logic            run,
    output logic            mc,
    output logic [PC_W-1:0] p_base,
    output logic            fp
);
    frame_state_t state, state_nx;

    logic [N_W-1:0] k;
    logic [A_W-1:0] a_act;
    logic [N_W-1:0] n_act;
    logic           psel_act;
    logic           last;
    logic           load;

    always_comb begin
        last = tick && (k == n_act - N_W'(1));
        load = (state == FR_LOAD) || last;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_LOAD:    state_nx = (a_in != '0) ? FR_SWALLOW : FR_MAIN;              // T_START
            FR_SWALLOW: begin
                if (last)
                    state_nx = (a_in != '0) ? FR_SWALLOW : FR_MAIN;                  // T_WRAP
                else if (tick && (k + N_W'(1) == N_W'(a_act)))
                    state_nx = FR_MAIN;                                              // T_RELEASE
            end
            FR_MAIN: begin
                if (last)
                    state_nx = (a_in != '0) ? FR_SWALLOW : FR_MAIN;                  // T_WRAP
            end
            default:    state_nx = FR_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= FR_LOAD;
        else
            state <= state_nx;
    end

    // Outputs decoded from the state.
    always_comb begin
        run    = (state != FR_LOAD);
        mc     = (state == FR_SWALLOW);
        p_base = psel_act ? PC_W'(P_SET) : PC_W'(P_CLR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k        <= '0;
            a_act    <= '0;
            n_act    <= N_W'(3);
            psel_act <= 1'b1;
            fp       <= 1'b0;
        end else begin
            fp <= last;
            if (load) begin
                k        <= '0;
                a_act    <= a_in;
                n_act    <= n_in;
                psel_act <= psel_in;
            end else if (tick) begin
                k <= k + N_W'(1);
            end
        end
    end

    assert_fp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    assert_no_swallow_a0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && a_act == '0) |-> !mc);

    assert_release_at_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mc) |-> (k == N_W'(a_act)));

    assert_cfg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable({a_act, n_act, psel_act}));

endmodule

// File: rtl/pswallow_ref_div.sv
module pswallow_ref_div
    import pswallow_pkg::*;
#(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_in,
    output logic           fr
);
    ref_state_t     state, state_nx;
    logic [R_W-1:0] rcnt;
    logic [R_W-1:0] r_act;
    logic           wrap;

    always_comb begin
        wrap     = (state == RF_COUNT) && (rcnt == r_act - R_W'(1));
        state_nx = state;
        unique case (state)
            RF_LOAD:  state_nx = RF_COUNT;   // T_RSTART
            RF_COUNT: state_nx = RF_COUNT;   // T_RWRAP when wrap
            default:  state_nx = RF_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RF_LOAD;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt  <= '0;
            r_act <= R_W'(3);
            fr    <= 1'b0;
        end else begin
            fr <= wrap;
            if (state == RF_LOAD || wrap) begin
                rcnt  <= '0;
                r_act <= r_in;
            end else begin
                rcnt <= rcnt + R_W'(1);
            end
        end
    end

    assert_fr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fr |=> !fr);

    assert_rcnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RF_COUNT) |-> (rcnt < r_act));

endmodule

// File: rtl/pswallow_synth_div.sv
module pswallow_synth_div #(
    parameter int A_W       = 7,
    parameter int N_W       = 11,
    parameter int R_W       = 14,
    parameter bit HIGH_BAND = 1'b0
) (
    input  logic           clk_vco,
    input  logic           clk_osc,
    input  logic           rst_n,
    input  logic [A_W-1:0] swallow_a,
    input  logic [N_W-1:0] main_n,
    input  logic [R_W-1:0] ref_r,
    input  logic           psel,
    output logic           fp,
    output logic           fr,
    output logic           mod_ctl
);
    localparam int P_SET = HIGH_BAND ? 64 : 8;
    localparam int P_CLR = HIGH_BAND ? 128 : 16;
    localparam int PC_W  = $clog2(P_CLR + 2);

    logic            run;
    logic            tick;
    logic [PC_W-1:0] p_base;

    pswallow_prescaler #(.PC_W(PC_W)) u_presc (
        .clk    (clk_vco),
        .rst_n  (rst_n),
        .run    (run),
        .mc     (mod_ctl),
        .p_base (p_base),
        .tick   (tick)
    );

    pswallow_frame_ctrl #(
        .A_W   (A_W),
        .N_W   (N_W),
        .PC_W  (PC_W),
        .P_SET (P_SET),
        .P_CLR (P_CLR)
    ) u_frame (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .tick    (tick),
        .a_in    (swallow_a),
        .n_in    (main_n),
        .psel_in (psel),
        .run     (run),
        .mc      (mod_ctl),
        .p_base  (p_base),
        .fp      (fp)
    );

    pswallow_ref_div #(.R_W(R_W)) u_ref (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .r_in  (ref_r),
        .fr    (fr)
    );

    assert_reset_quiet_R8: assert property (@(posedge clk_vco)
        !rst_n |-> (!fp && !mod_ctl));

endmodule

// File: tb/pswallow_synth_div_bench.sv
module pswallow_synth_div_bench;
    logic        clk_vco = 1'b0;
    logic        clk_osc = 1'b0;
    logic        rst_n   = 1'b0;
    logic [6:0]  swallow_a = 7'd0;
    logic [10:0] main_n    = 11'd3;
    logic [13:0] ref_r     = 14'd5;
    logic        psel      = 1'b1;
    logic        fp_lb, fr_lb, mc_lb;
    logic        fp_hb, fr_hb, mc_hb;
    logic        sel_hb = 1'b0;
    logic        fp_m, mc_m;

    int n_chk  = 0;
    int n_fail = 0;
    int prev_ratio;
    bit done = 1'b0;

    always #5  clk_vco = ~clk_vco;
    always #13 clk_osc = ~clk_osc;

    assign fp_m = sel_hb ? fp_hb : fp_lb;
    assign mc_m = sel_hb ? mc_hb : mc_lb;

    pswallow_synth_div #(.HIGH_BAND(1'b0)) u_pswallow_synth_div (
        .clk_vco(clk_vco), .clk_osc(clk_osc), .rst_n(rst_n),
        .swallow_a(swallow_a), .main_n(main_n), .ref_r(ref_r), .psel(psel),
        .fp(fp_lb), .fr(fr_lb), .mod_ctl(mc_lb));

    pswallow_synth_div #(.HIGH_BAND(1'b1)) u_pswallow_synth_div_hb (
        .clk_vco(clk_vco), .clk_osc(clk_osc), .rst_n(rst_n),
        .swallow_a(swallow_a), .main_n(main_n), .ref_r(ref_r), .psel(psel),
        .fp(fp_hb), .fr(fr_hb), .mod_ctl(mc_hb));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pval(input bit hb, input bit ps);
        if (hb) return ps ? 64 : 128;
        return ps ? 8 : 16;
    endfunction

    // Starts on a cycle where fp was sampled high, ends on the next one.
    // Applies a new setting two cycles in; the frame in progress keeps the old ratio.
    task automatic step(input int a, input int n, input bit ps);
        int cyc = 0;
        int mcnt = 0;
        int ratio;
        int after_fp;
        do begin
            @(negedge clk_vco);
            cyc++;
            if (cyc == 1) after_fp = int'(fp_m);
            if (cyc == 2) begin
                swallow_a = 7'(a); main_n = 11'(n); psel = ps;
            end
        end while (!fp_m);
        chk("R5 old ratio kept mid-frame", cyc, prev_ratio);
        chk("R7 fp single cycle", after_fp, 0);
        ratio = pval(sel_hb, ps) * n + a;
        cyc = 0;
        do begin
            if (mc_m) mcnt++;
            @(negedge clk_vco);
            cyc++;
        end while (!fp_m);
        chk(sel_hb ? "R1 R4 high-band period" : "R1 R4 period", cyc, ratio);
        chk(a == 0 ? "R3 no swallow when A=0" : "R2 swallow cycles", mcnt, a * (pval(sel_hb, ps) + 1));
        prev_ratio = ratio;
    endtask

    task automatic sync_fp();
        do @(negedge clk_vco); while (!fp_m);
    endtask

    task automatic ref_step(input int r_new, input int r_old);
        int cyc = 0;
        do begin
            @(negedge clk_osc);
            cyc++;
            if (cyc == 1) chk("R7 fr single cycle", int'(fr_lb), 0);
            if (cyc == 2) ref_r = 14'(r_new);
        end while (!fr_lb);
        chk("R6 old R kept mid-period", cyc, r_old);
        cyc = 0;
        do begin @(negedge clk_osc); cyc++; end while (!fr_lb);
        chk("R6 reference period", cyc, r_new);
    endtask

    initial begin
        repeat (4) @(negedge clk_vco);
        chk("R8 fp low in reset", int'(fp_lb), 0);
        chk("R8 mod_ctl low in reset", int'(mc_lb), 0);
        chk("R8 fr low in reset", int'(fr_lb), 0);
        rst_n = 1'b1;

        // Low band: every legal A for small N, both prescaler pairs.
        prev_ratio = 8 * 3;
        sync_fp();
        for (int ps = 1; ps >= 0; ps--)
            for (int n = 3; n <= 8; n++)
                for (int a = 0; a < n; a++)
                    step(a, n, ps[0]);
        step(127, 130, 1'b0);
        step(0, 1023, 1'b1);
        step(5, 40, 1'b1);

        // High band: resynchronise on the other instance, discarding one frame.
        sel_hb = 1'b1;
        swallow_a = 7'd0; main_n = 11'd3; psel = 1'b1;
        sync_fp(); sync_fp();
        prev_ratio = 64 * 3;
        step(2, 3, 1'b1);
        step(0, 4, 1'b0);
        step(3, 5, 1'b0);

        // Reference divider.
        do @(negedge clk_osc); while (!fr_lb);
        do @(negedge clk_osc); while (!fr_lb);
        begin
            int r_prev = 5;
            for (int r = 3; r <= 20; r++) begin
                ref_step(r, r_prev);
                r_prev = r;
            end
            ref_step(300, r_prev);
        end
        done = 1'b1;
    end

    initial begin
        int cnt = 0;
        while (!done && cnt < 190000) begin
            @(posedge clk_vco);
            cnt++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule